// File: doc/BRIEF.md
# Input Signal Level Detector

This block watches the wideband level of one stream of 16-bit two's-complement samples, such as the raw output of an A/D converter. A processor reads the measured level and uses it to steer an analogue gain or attenuation stage placed ahead of that converter. Each accepted sample is reduced to its magnitude and accumulated in one of two ways.

In integrate mode the magnitudes are summed over a programmed number of samples. At the end of each interval the sum moves to a 32-bit result register and a new interval begins. In leaky mode a first-order recursive average runs without stopping. Its leak coefficient is a power of two, so every multiply becomes a right shift. In both modes a ready flag tells the processor that a fresh result is waiting, and a read strobe clears the flag.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is low only while reset is applied and for the first clock after reset, and high at all other times. A sample transfers on any rising edge where `in_valid` and `in_ready` are both high. A source may hold `in_valid` high for any number of cycles, and each cycle with both signals high counts as one sample.

Top module: `lvl_detect`

## Requirements
- R1: While `rst_n` is low, `in_ready` is low, `level_out` is zero and `level_rdy` is low. After reset is released, `in_ready` is high on every cycle.
- R2: The magnitude of a sample is its two's-complement absolute value, except that the input 16'h8000 (-32768) gives 32767.
- R3: When `cfg_leaky` is 0 (integrate mode), N = `cfg_len` + 2 contributing magnitudes are summed. On the edge that accepts the N-th sample, the sum including that sample is written to `level_out` and the accumulator is cleared. The next interval starts with the next contributing sample, with no sample lost. `level_out` changes on no other edge.
- R4: The interval length covers its whole range: `cfg_len` = 0 gives 2 samples and `cfg_len` = 65535 gives 65537 samples, with no wrap of the 32-bit sum when every sample is -32768.
- R5: When `cfg_leaky` is 1, each contributing sample with magnitude m updates Y to Y - (Y >> s) + ((m << 16) >> s). The shift s is 0, 8, 12 or 16 for `cfg_leak_sel` codes 0, 1, 2 and 3. The new Y is written to `level_out` on the same edge.
- R6: In leaky mode with `cfg_leak_sel` = 0, `level_out` becomes m << 16 for the latest contributing sample, whatever came before it.
- R7: When `cfg_cplx` is 1, accepted samples alternate between I and Q, starting with I after each restart. Q samples change neither the sum, the recursive average nor the interval count.
- R8: `level_rdy` goes high on every edge that writes `level_out`. It goes low on an edge where `rd_strobe` is high and no write occurs. If a write and a read strobe fall on the same edge, the flag stays high.
- R9: Any change to `cfg_leaky`, `cfg_leak_sel`, `cfg_cplx` or `cfg_len` restarts the measurement on the next edge. That edge clears the accumulator, the interval count and the I/Q phase, and drops any sample offered in that same cycle. `level_out` and `level_rdy` are left unchanged by a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 16 | Sample, two's complement |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted on this edge when valid is high |
| cfg_leaky | input | 1 | 0 integrate mode, 1 leaky mode |
| cfg_leak_sel | input | 2 | Leak coefficient code, shift 0/8/12/16 |
| cfg_cplx | input | 1 | Interleaved I/Q input, only I measured |
| cfg_len | input | 16 | Interval length minus two |
| rd_strobe | input | 1 | Processor read of the result, clears the ready flag |
| level_out | output | 32 | Latest measured level |
| level_rdy | output | 1 | A result has been written and not yet read |

## Verification
The bench feeds -32768 and checks the result. A design that negates it without saturation would add 32768 per sample and produce sums that are off by one per sample, or negative. The bench runs the shortest interval of 2 samples and the longest of 65537 samples of maximum magnitude, which exposes an off-by-one in the terminal count or a narrow counter that wraps early.

The bench also interleaves large Q values with small I values, so a design that mixes Q into the measurement returns results far off the expected ones. Configuration changes arrive mid-interval and together with a junk sample, so a design that keeps stale partial sums or accepts the junk sample reports the wrong total. Leaky mode is driven with a sample on every cycle, so the read strobe and a new result land on the same edge. A design that lets the clear win loses a result, and a result is left waiting in the scoreboard.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

  typedef enum logic {
    LVL_INTEG = 1'b0,
    LVL_LEAKY = 1'b1
  } lvl_mode_e;

  localparam int SHIFT_W = 5;

  // Leak coefficient code to right-shift distance.
  function automatic logic [SHIFT_W-1:0] leak_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return 5'd8;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/lvl_mag.sv
module lvl_mag #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mag
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (din == MOST_NEG)      mag = MOST_POS;
    else if (din[DATA_W-1])   mag = -din;
    else                      mag = din;
  end
endmodule

// File: rtl/lvl_ctrl.sv
module lvl_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             cfg_leaky,
  input  logic [1:0]       cfg_leak_sel,
  input  logic             cfg_cplx,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             in_ready,
  output logic             restart,
  output logic             take,
  output logic             last
);
  localparam int CNT_W = LEN_W + 1;
  localparam int CFG_W = LEN_W + 4;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_end;
  logic             q_phase;
  logic             rdy_q;
  logic             accept;

  assign cfg_now  = {cfg_leaky, cfg_leak_sel, cfg_cplx, cfg_len};
  assign restart  = rdy_q && (cfg_now != cfg_q);
  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q && !restart;
  assign take     = accept && (!cfg_cplx || !q_phase);
  assign cnt_end  = CNT_W'(cfg_len) + CNT_W'(1);
  assign last     = take && (cfg_leaky == lvl_pkg::LVL_INTEG) && (cnt == cnt_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      cfg_q   <= '0;
      cnt     <= '0;
      q_phase <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      cfg_q <= cfg_now;
      if (restart) begin
        cnt     <= '0;
        q_phase <= 1'b0;
      end else begin
        if (accept && cfg_cplx) q_phase <= !q_phase;
        if (take && !cfg_leaky) cnt <= last ? '0 : cnt + CNT_W'(1);
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt <= cnt_end));
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !q_phase));
  p_q_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_cplx && q_phase) |=> (cnt == $past(cnt)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0));
endmodule

// File: rtl/lvl_accum.sv
module lvl_accum #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic              last,
  input  logic              leaky,
  input  logic [1:0]        leak_sel,
  input  logic [DATA_W-1:0] mag,
  output logic [ACC_W-1:0]  upd_val
);
  import lvl_pkg::*;
  localparam int FRAC = ACC_W - DATA_W;

  logic [ACC_W-1:0]   acc, sum_next, leak_next, x_wide;
  logic [SHIFT_W-1:0] sh;

  generate
    if (FRAC > 0) begin : g_frac
      assign x_wide = {mag, {FRAC{1'b0}}};
    end else begin : g_nofrac
      assign x_wide = ACC_W'(mag);
    end
  endgenerate

  assign sh        = leak_shift(leak_sel);
  assign sum_next  = acc + ACC_W'(mag);
  assign leak_next = acc - (acc >> sh) + (x_wide >> sh);
  assign upd_val   = leaky ? leak_next : sum_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (restart) begin
      acc <= '0;
    end else if (take) begin
      if (leaky)     acc <= leak_next;
      else if (last) acc <= '0;
      else           acc <= sum_next;
    end
  end

  p_dump_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (acc == '0));
  p_leak_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && leaky && leak_sel == 2'd0 && !restart) |=> (acc == $past(x_wide)));
endmodule

// File: rtl/lvl_detect.sv
module lvl_detect #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              cfg_leaky,
  input  logic [1:0]        cfg_leak_sel,
  input  logic              cfg_cplx,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              rd_strobe,
  output logic [ACC_W-1:0]  level_out,
  output logic              level_rdy
);
  logic              restart, take, last, upd;
  logic [DATA_W-1:0] mag;
  logic [ACC_W-1:0]  upd_val;

  lvl_mag #(.DATA_W(DATA_W)) u_mag (
    .din (in_data),
    .mag (mag)
  );

  lvl_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .cfg_leaky    (cfg_leaky),
    .cfg_leak_sel (cfg_leak_sel),
    .cfg_cplx     (cfg_cplx),
    .cfg_len      (cfg_len),
    .in_ready     (in_ready),
    .restart      (restart),
    .take         (take),
    .last         (last)
  );

  lvl_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .take     (take),
    .last     (last),
    .leaky    (cfg_leaky),
    .leak_sel (cfg_leak_sel),
    .mag      (mag),
    .upd_val  (upd_val)
  );

  assign upd = take && (cfg_leaky || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_out <= '0;
      level_rdy <= 1'b0;
    end else begin
      if (upd) level_out <= upd_val;
      if (upd)            level_rdy <= 1'b1;
      else if (rd_strobe) level_rdy <= 1'b0;
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> level_rdy);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !upd) |=> !level_rdy);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(level_out));
  p_restart_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !rd_strobe) |=> ($stable(level_out) && $stable(level_rdy)));
endmodule

// File: tb/lvl_detect_bench.sv
module lvl_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        cfg_leaky = 1'b0;
  logic [1:0]  cfg_leak_sel = '0;
  logic        cfg_cplx = 1'b0;
  logic [15:0] cfg_len = '0;
  logic        rd_strobe = 1'b0;
  logic [31:0] level_out;
  logic        level_rdy;

  always #4 clk = ~clk;

  lvl_detect u_lvl_detect (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_leaky(cfg_leaky), .cfg_leak_sel(cfg_leak_sel),
    .cfg_cplx(cfg_cplx), .cfg_len(cfg_len), .rd_strobe(rd_strobe),
    .level_out(level_out), .level_rdy(level_rdy)
  );

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 0;
  string       cur_tag = "R3";
  logic [31:0] expq[$];
  logic [31:0] exp_v;

  // reference model state
  bit          m_leaky, m_cplx, m_ph;
  int          m_sel, m_n, m_cnt;
  logic [31:0] m_sum, m_y;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] mag16(logic [15:0] v);
    if (v == 16'h8000) return 16'h7FFF;
    if (v[15]) return -v;
    return v;
  endfunction

  task automatic model(logic [15:0] v);
    logic [15:0] a;
    int s;
    if (m_cplx && m_ph) begin m_ph = 0; return; end
    if (m_cplx) m_ph = 1;
    a = mag16(v);
    if (m_leaky) begin
      s = (m_sel == 0) ? 0 : (m_sel == 1) ? 8 : (m_sel == 2) ? 12 : 16;
      m_y = m_y - (m_y >> s) + ({a, 16'h0} >> s);
      expq.push_back(m_y);
    end else begin
      m_sum = m_sum + 32'(a);
      m_cnt++;
      if (m_cnt == m_n) begin
        expq.push_back(m_sum);
        m_sum = '0;
        m_cnt = 0;
      end
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic send(logic [15:0] v);
    in_data  = v;
    in_valid = 1'b1;
    model(v);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(bit lk, int sel, bit cx, int len, bit junk, string tag);
    repeat (2) @(negedge clk);
    cur_tag      = tag;
    cfg_leaky    = lk;
    cfg_leak_sel = 2'(sel);
    cfg_cplx     = cx;
    cfg_len      = 16'(len);
    if (junk) begin in_data = 16'd9999; in_valid = 1'b1; end
    @(negedge clk);
    in_valid = 1'b0;
    m_leaky = lk; m_sel = sel; m_cplx = cx; m_n = len + 2;
    m_sum = '0; m_cnt = 0; m_ph = 0; m_y = '0;
  endtask

  // monitor: scoreboard compare and read strobe
  always @(negedge clk) begin
    if (rst_n && level_rdy) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected ready flag", level_out, 32'd0);
      end else begin
        exp_v = expq.pop_front();
        chk(level_out == exp_v, cur_tag, level_out, exp_v);
      end
      rd_strobe <= 1'b1;
    end else begin
      rd_strobe <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 180000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_leaky = 0; m_cplx = 0; m_ph = 0; m_sel = 0; m_n = 2; m_cnt = 0;
    m_sum = '0; m_y = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1 in_ready in reset", 32'(in_ready), 32'd0);
    chk(level_out == 32'd0, "R1 level_out in reset", level_out, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    chk(level_out == 32'd0, "R1 level_out after reset", level_out, 32'd0);
    chk(level_rdy == 1'b0, "R1 level_rdy after reset", 32'(level_rdy), 32'd0);

    // R3 R2: four-sample intervals back to back, including saturation
    set_cfg(0, 0, 0, 2, 0, "R3 R2 integrate");
    send(16'd100); send(-16'sd200); send(16'd300); send(16'h8000);
    send(16'd1); send(16'd2); send(16'd3); send(16'd4);

    // R4: shortest interval
    set_cfg(0, 0, 0, 0, 0, "R4 shortest interval");
    send(16'd5); send(-16'sd7); send(16'd11); send(16'd13);

    // R9: partial interval then change with junk sample in same cycle
    set_cfg(0, 0, 0, 2, 0, "R9 restart");
    send(16'd50); send(16'd60);
    set_cfg(0, 0, 0, 1, 1, "R9 restart drops partial and junk");
    send(16'd1); send(16'd2); send(16'd3);

    // R7: interleaved I/Q, Q ignored
    set_cfg(0, 0, 1, 0, 0, "R7 complex integrate");
    send(16'd10); send(16'd30000); send(-16'sd20); send(-16'sd30000);
    send(16'd7);  send(16'd12345); send(16'd8);   send(16'h8000);

    // R6: unity leak, back-to-back so reads coincide with writes (R8)
    set_cfg(1, 0, 0, 0, 0, "R6 R8 unity leak");
    send(16'd1000); send(-16'sd5); send(16'h8000); send(16'd0);

    // R5: leak shifts 8, 12, 16
    set_cfg(1, 1, 0, 0, 0, "R5 leak shift 8");
    for (int i = 0; i < 6; i++) send(16'd20000);
    send(-16'sd3000);
    set_cfg(1, 2, 0, 0, 0, "R5 leak shift 12");
    for (int i = 0; i < 4; i++) send(16'h8000);
    set_cfg(1, 3, 0, 0, 0, "R5 leak shift 16");
    for (int i = 0; i < 3; i++) send(16'd32767);

    // R7 with leaky mode
    set_cfg(1, 1, 1, 0, 0, "R7 R5 complex leaky");
    send(16'd400); send(16'd32000); send(-16'sd800); send(-16'sd32000);

    // R4 R2: longest interval at maximum magnitude
    set_cfg(0, 0, 0, 65535, 0, "R4 R2 longest interval");
    for (int i = 0; i < 65537; i++) send(16'h8000);

    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R8 every result flagged", 32'(expq.size()), 32'd0);
    chk(level_rdy == 1'b0, "R8 flag cleared by read", 32'(level_rdy), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule